// File: doc/BRIEF.md
# Sigma-Delta Converter Register Port

This block is the serial register port of a multi-register sigma-delta converter. It is an SPI mode-3 slave that runs from a system clock faster than the serial clock. The serial clock idles high. The slave moves its output on falling edges and takes its input on rising edges, shifting the most significant bit first. Every access begins with one command byte. That byte names one of eight register addresses, a direction and an optional streaming request. The data phase that follows is 8, 16 or `DW` bits long, depending on the address.

The port holds the writable settings: operating mode, configuration, excitation IO, offset and gain calibration. It drives them to the rest of the converter as parallel outputs. Conversion results enter on a parallel bus with a one-cycle valid strobe. They set a not-ready flag, which the host sees in the status byte and also on MISO while chip select is low and no data is moving. A streaming mode returns each new result without a fresh command byte. A long run of ones on MOSI, or a release of chip select, brings the port back to waiting for a command.

The frame controller has four named states. `S_CMD` collects the eight command bits. `S_WRITE` collects a write payload. `S_READ` shifts out one register. `S_STREAM` shifts out result words again and again. Five transitions connect them:

- accept-read goes from `S_CMD` to `S_READ`.
- accept-write goes from `S_CMD` to `S_WRITE`.
- accept-stream goes from `S_CMD` to `S_STREAM`.
- phase-done goes from `S_READ` or `S_WRITE` back to `S_CMD`.
- stream-exit goes from `S_STREAM` back to `S_CMD`.

Two transitions can leave any state for `S_CMD`: chip-select release and resync.

Top module: `sdadc_spi_port`

## Requirements
- R1: A command byte is accepted only when its bit 7 is 0. Bit 6 = 1 means read, bits 5:3 give the address and bit 2 requests streaming. A byte with bit 7 set is dropped, and the next 8 bits are taken as a new command.
- R2: A read returns the addressed register MSB first. The lengths are: 8 bits for address 0 (status), 4 (ID) and 5 (IO); 16 bits for 1 (mode) and 2 (configuration); `DW` bits for 3 (data), 6 (offset) and 7 (gain).
- R3: A write to address 1, 2, 5, 6 or 7 stores the clocked payload (16, 16, 8, `DW` and `DW` bits). The stored value appears on the matching output port and reads back unchanged.
- R4: A write to address 3 or 4 clocks its full payload but changes nothing. A write to address 0 has no data phase, so the next 8 bits are a new command.
- R5: The status byte is {not-ready, error, 3'b000, channel[2:0]}.
- R6: The ID read returns the `DEV_ID` parameter (default 8'h4B).
- R7: A `conv_valid` pulse stores `conv_data`, `conv_err` and `conv_chan` and clears not-ready. While chip select is low and no data bit is being driven, MISO shows the not-ready flag.
- R8: Not-ready is set again only when a full data-register read completes. It stays clear after a read aborted by chip select, and after a read during which a newer result arrived. That read still returns the value it started with.
- R9: Command 8'h5C enters streaming. While not-ready is high the port only shows not-ready on MISO. Once it is low, each `DW`-clock word shifts out the data register. If the first 8 MOSI bits of a word equal 8'h58, the port returns to command wait after that word.
- R10: 32 consecutive ones sampled on MOSI return the port to command wait from any state, with registers kept. Hosts hold MOSI low during reads.
- R11: Raising chip select aborts any transaction and returns the port to command wait. MISO is 1 while chip select is high.
- R12: After reset: mode 16'h000A, configuration 16'h0710, IO 8'h00, offset 1<<(DW-1), gain 5<<(DW-4), status 8'h80, data 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sclk | input | 1 | Serial clock, idles high |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data in |
| spi_miso | output | 1 | Serial data out / not-ready indication |
| conv_valid | input | 1 | One-cycle strobe for a new result |
| conv_data | input | DW | Conversion result |
| conv_err | input | 1 | Range error of the result |
| conv_chan | input | 3 | Channel of the result |
| mode_cfg | output | 16 | Mode register |
| conf_cfg | output | 16 | Configuration register |
| io_cfg | output | 8 | Excitation IO register |
| offset_cfg | output | DW | Offset calibration register |
| gain_cfg | output | DW | Gain calibration register |

## Verification
A wrong frame state loses alignment, and that shows at the ports within one command. Once the bit counter or the state is off, the next command byte is split across a data phase. The following ID or register read then returns a shifted or foreign value, and an unintended write shows up at once on a configuration output. A wrong not-ready flag shows as soon as chip select falls, because MISO mirrors it. It also shows in the next status byte and in whether streaming releases a word. Each scenario is therefore followed within one transaction by an ID, register or status read that exposes the fault.

// File: rtl/sdadc_spi_pkg.sv
`timescale 1ns/1ps
package sdadc_spi_pkg;

    typedef enum logic [1:0] {
        S_CMD    = 2'd0,
        S_WRITE  = 2'd1,
        S_READ   = 2'd2,
        S_STREAM = 2'd3
    } port_state_e;

    localparam logic [2:0] A_STAT = 3'd0;
    localparam logic [2:0] A_MODE = 3'd1;
    localparam logic [2:0] A_CONF = 3'd2;
    localparam logic [2:0] A_DATA = 3'd3;
    localparam logic [2:0] A_IDNT = 3'd4;
    localparam logic [2:0] A_IO   = 3'd5;
    localparam logic [2:0] A_OFS  = 3'd6;
    localparam logic [2:0] A_GAIN = 3'd7;

    localparam logic [7:0] STREAM_STOP = 8'h58;
    localparam int RESYNC_ONES = 32;

    // payload length in bits for each address
    function automatic int unsigned field_len(input logic [2:0] a, input int unsigned dw);
        case (a)
            A_MODE, A_CONF:        return 16;
            A_DATA, A_OFS, A_GAIN: return dw;
            default:               return 8;
        endcase
    endfunction

endpackage

// File: rtl/sdadc_spi_sync.sv
`timescale 1ns/1ps
module sdadc_spi_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk,
    input  logic cs_n,
    input  logic mosi,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic cs_idle,
    output logic mosi_s
);
    logic [STAGES:0]   sclk_q;
    logic [STAGES-1:0] cs_q;
    logic [STAGES-1:0] mosi_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_q <= '1;
            cs_q   <= '1;
            mosi_q <= '0;
        end else begin
            sclk_q <= {sclk_q[STAGES-1:0], sclk};
            cs_q   <= {cs_q[STAGES-2:0], cs_n};
            mosi_q <= {mosi_q[STAGES-2:0], mosi};
        end
    end

    assign sclk_rise = sclk_q[STAGES-1] & ~sclk_q[STAGES];
    assign sclk_fall = ~sclk_q[STAGES-1] & sclk_q[STAGES];
    assign cs_idle   = cs_q[STAGES-1];
    assign mosi_s    = mosi_q[STAGES-1];
endmodule

// File: rtl/sdadc_spi_frame.sv
`timescale 1ns/1ps
module sdadc_spi_frame
    import sdadc_spi_pkg::*;
#(
    parameter int DW = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rise,
    input  logic          fall,
    input  logic          cs_idle,
    input  logic          mosi_s,
    input  logic [DW-1:0] rd_val,
    input  logic          rdy_n,
    output logic [2:0]    reg_addr,
    output logic          wr_en,
    output logic [DW-1:0] wr_data,
    output logic          ld_data,
    output logic          rd_done,
    output logic          miso
);
    localparam int LW = $clog2(DW + 1);
    localparam int OW = $clog2(RESYNC_ONES + 1);

    port_state_e   st_q, st_d;
    logic [2:0]    addr_q;
    logic [LW-1:0] len_q, cnt_q;
    logic [6:0]    cmd_q;
    logic [DW-2:0] wsh_q;
    logic [DW-1:0] tx_q;
    logic          miso_q, drv_q, stop_q;
    logic [OW-1:0] ones_q;
    logic          wr_en_q, ld_q, done_q;
    logic [DW-1:0] wr_data_q;

    logic [7:0]    cmd_byte;
    logic          last_bit, word_end, resync;
    logic [DW-1:0] ld_val;

    assign cmd_byte = {cmd_q, mosi_s};
    assign last_bit = (cnt_q == len_q - LW'(1));
    assign word_end = (cnt_q == LW'(DW - 1));
    assign resync   = rise && mosi_s && (ones_q == OW'(RESYNC_ONES - 1));
    assign ld_val   = rd_val << (LW'(DW) - len_q);

    // next-state logic
    always_comb begin
        st_d = st_q;
        if (cs_idle || resync) begin
            st_d = S_CMD;
        end else if (rise) begin
            unique case (st_q)
                S_CMD: begin
                    if (cnt_q == LW'(7) && !cmd_byte[7]) begin
                        if (cmd_byte[6])
                            st_d = (cmd_byte[5:3] == A_DATA && cmd_byte[2]) ? S_STREAM : S_READ;
                        else if (cmd_byte[5:3] != A_STAT)
                            st_d = S_WRITE;
                    end
                end
                S_WRITE, S_READ: if (last_bit) st_d = S_CMD;
                S_STREAM:        if (word_end && stop_q) st_d = S_CMD;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= S_CMD;
        else        st_q <= st_d;
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= A_STAT; len_q <= LW'(8); cnt_q <= '0; cmd_q <= '0;
            wsh_q <= '0; tx_q <= '0; miso_q <= 1'b1; drv_q <= 1'b0;
            stop_q <= 1'b0; ones_q <= '0; wr_en_q <= 1'b0; ld_q <= 1'b0;
            done_q <= 1'b0; wr_data_q <= '0;
        end else begin
            wr_en_q <= 1'b0;
            ld_q    <= 1'b0;
            done_q  <= 1'b0;
            if (cs_idle) begin
                cnt_q <= '0; ones_q <= '0; drv_q <= 1'b0; stop_q <= 1'b0; miso_q <= 1'b1;
            end else begin
                if (rise) begin
                    ones_q <= (mosi_s && !resync) ? ones_q + OW'(1) : '0;
                    if (resync) begin
                        cnt_q <= '0; drv_q <= 1'b0; stop_q <= 1'b0;
                    end else begin
                        unique case (st_q)
                            S_CMD: begin
                                cmd_q <= cmd_byte[6:0];
                                if (cnt_q == LW'(7)) begin
                                    cnt_q  <= '0;
                                    addr_q <= cmd_byte[5:3];
                                    len_q  <= LW'(field_len(cmd_byte[5:3], DW));
                                end else begin
                                    cnt_q <= cnt_q + LW'(1);
                                end
                            end
                            S_WRITE: begin
                                wsh_q <= {wsh_q[DW-3:0], mosi_s};
                                if (last_bit) begin
                                    cnt_q     <= '0;
                                    wr_en_q   <= 1'b1;
                                    wr_data_q <= {wsh_q, mosi_s};
                                end else begin
                                    cnt_q <= cnt_q + LW'(1);
                                end
                            end
                            S_READ: begin
                                if (last_bit) begin
                                    cnt_q  <= '0;
                                    drv_q  <= 1'b0;
                                    done_q <= (addr_q == A_DATA);
                                end else begin
                                    cnt_q <= cnt_q + LW'(1);
                                end
                            end
                            S_STREAM: begin
                                if (cnt_q < LW'(8)) cmd_q <= cmd_byte[6:0];
                                if (cnt_q == LW'(7) && cmd_byte == STREAM_STOP) stop_q <= 1'b1;
                                if (word_end) begin
                                    cnt_q  <= '0;
                                    drv_q  <= 1'b0;
                                    done_q <= 1'b1;
                                    stop_q <= 1'b0;
                                end else begin
                                    cnt_q <= cnt_q + LW'(1);
                                end
                            end
                        endcase
                    end
                end
                if (fall && (st_q == S_READ || (st_q == S_STREAM && (drv_q || !rdy_n)))) begin
                    if (!drv_q) begin
                        {miso_q, tx_q} <= {ld_val, 1'b0};
                        drv_q <= 1'b1;
                        ld_q  <= (addr_q == A_DATA);
                    end else begin
                        {miso_q, tx_q} <= {tx_q, 1'b0};
                    end
                end
            end
        end
    end

    assign reg_addr = addr_q;
    assign wr_en    = wr_en_q;
    assign wr_data  = wr_data_q;
    assign ld_data  = ld_q;
    assign rd_done  = done_q;
    assign miso     = cs_idle ? 1'b1 : (drv_q ? miso_q : rdy_n);

    // R1: a guarded byte never leaves command wait
    p_guard_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == S_CMD && rise && !cs_idle && cnt_q == LW'(7) && cmd_q[6]) |=> (st_q == S_CMD));
    // R10: the 32nd consecutive one realigns the port
    p_resync_home_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rise && !cs_idle && mosi_s && ones_q == OW'(RESYNC_ONES - 1)) |=> (st_q == S_CMD && cnt_q == '0));
    // R11: chip-select release clears the frame
    p_cs_home_r11: assert property (@(posedge clk) disable iff (!rst_n)
        cs_idle |=> (st_q == S_CMD && !drv_q));
    // R9: output bits are only driven inside a read or stream word
    p_drive_scope_r9: assert property (@(posedge clk) disable iff (!rst_n)
        drv_q |-> (st_q == S_READ || st_q == S_STREAM));
endmodule

// File: rtl/sdadc_spi_regs.sv
`timescale 1ns/1ps
module sdadc_spi_regs
    import sdadc_spi_pkg::*;
#(
    parameter int          DW       = 24,
    parameter logic [7:0]  DEV_ID   = 8'h4B,
    parameter logic [15:0] MODE_RST = 16'h000A,
    parameter logic [15:0] CONF_RST = 16'h0710,
    parameter logic [7:0]  IO_RST   = 8'h00
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [2:0]    reg_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          ld_data,
    input  logic          rd_done,
    input  logic          conv_valid,
    input  logic [DW-1:0] conv_data,
    input  logic          conv_err,
    input  logic [2:0]    conv_chan,
    output logic [DW-1:0] rd_val,
    output logic          rdy_n,
    output logic [15:0]   mode_cfg,
    output logic [15:0]   conf_cfg,
    output logic [7:0]    io_cfg,
    output logic [DW-1:0] offset_cfg,
    output logic [DW-1:0] gain_cfg
);
    localparam logic [DW-1:0] OFS_RST  = DW'(1) << (DW - 1);
    localparam logic [DW-1:0] GAIN_RST = DW'(5) << (DW - 4);

    logic [15:0]   mode_q, conf_q;
    logic [7:0]    io_q;
    logic [DW-1:0] ofs_q, gain_q, data_q;
    logic          err_q, rdy_n_q, inflight_q;
    logic [2:0]    chan_q;
    logic [7:0]    status;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= MODE_RST; conf_q <= CONF_RST; io_q <= IO_RST;
            ofs_q <= OFS_RST; gain_q <= GAIN_RST;
        end else if (wr_en) begin
            case (reg_addr)
                A_MODE:  mode_q <= wr_data[15:0];
                A_CONF:  conf_q <= wr_data[15:0];
                A_IO:    io_q   <= wr_data[7:0];
                A_OFS:   ofs_q  <= wr_data;
                A_GAIN:  gain_q <= wr_data;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0; err_q <= 1'b0; chan_q <= '0;
            rdy_n_q <= 1'b1; inflight_q <= 1'b0;
        end else if (conv_valid) begin
            data_q <= conv_data; err_q <= conv_err; chan_q <= conv_chan;
            rdy_n_q <= 1'b0; inflight_q <= 1'b0;
        end else begin
            if (ld_data) inflight_q <= 1'b1;
            if (rd_done && inflight_q) begin
                rdy_n_q    <= 1'b1;
                inflight_q <= 1'b0;
            end
        end
    end

    assign status = {rdy_n_q, err_q, 3'b000, chan_q};

    always_comb begin
        rd_val = '0;
        unique case (reg_addr)
            A_STAT: rd_val = DW'(status);
            A_MODE: rd_val = DW'(mode_q);
            A_CONF: rd_val = DW'(conf_q);
            A_DATA: rd_val = data_q;
            A_IDNT: rd_val = DW'(DEV_ID);
            A_IO:   rd_val = DW'(io_q);
            A_OFS:  rd_val = ofs_q;
            A_GAIN: rd_val = gain_q;
        endcase
    end

    assign rdy_n      = rdy_n_q;
    assign mode_cfg   = mode_q;
    assign conf_cfg   = conf_q;
    assign io_cfg     = io_q;
    assign offset_cfg = ofs_q;
    assign gain_cfg   = gain_q;

    // R7: a new result always clears not-ready
    p_result_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        conv_valid |=> !rdy_n_q);
    // R8: not-ready only rises on a completed data read
    p_ready_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rdy_n_q) |-> $past(rd_done));
    // R3: settings move only on a write strobe
    p_cfg_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(mode_q) && $stable(conf_q) && $stable(io_q) && $stable(ofs_q) && $stable(gain_q)));
endmodule

// File: rtl/sdadc_spi_port.sv
`timescale 1ns/1ps
module sdadc_spi_port
    import sdadc_spi_pkg::*;
#(
    parameter int          DW          = 24,
    parameter int          SYNC_STAGES = 2,
    parameter logic [7:0]  DEV_ID      = 8'h4B,
    parameter logic [15:0] MODE_RST    = 16'h000A,
    parameter logic [15:0] CONF_RST    = 16'h0710,
    parameter logic [7:0]  IO_RST      = 8'h00
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          spi_sclk,
    input  logic          spi_cs_n,
    input  logic          spi_mosi,
    output logic          spi_miso,
    input  logic          conv_valid,
    input  logic [DW-1:0] conv_data,
    input  logic          conv_err,
    input  logic [2:0]    conv_chan,
    output logic [15:0]   mode_cfg,
    output logic [15:0]   conf_cfg,
    output logic [7:0]    io_cfg,
    output logic [DW-1:0] offset_cfg,
    output logic [DW-1:0] gain_cfg
);
    logic          rise, fall, cs_idle, mosi_s;
    logic [DW-1:0] rd_val, wr_data;
    logic [2:0]    reg_addr;
    logic          wr_en, ld_data, rd_done, rdy_n;

    sdadc_spi_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .sclk(spi_sclk), .cs_n(spi_cs_n), .mosi(spi_mosi),
        .sclk_rise(rise), .sclk_fall(fall), .cs_idle(cs_idle), .mosi_s(mosi_s)
    );

    sdadc_spi_frame #(.DW(DW)) u_frame (
        .clk(clk), .rst_n(rst_n), .rise(rise), .fall(fall), .cs_idle(cs_idle),
        .mosi_s(mosi_s), .rd_val(rd_val), .rdy_n(rdy_n), .reg_addr(reg_addr),
        .wr_en(wr_en), .wr_data(wr_data), .ld_data(ld_data), .rd_done(rd_done),
        .miso(spi_miso)
    );

    sdadc_spi_regs #(
        .DW(DW), .DEV_ID(DEV_ID), .MODE_RST(MODE_RST), .CONF_RST(CONF_RST), .IO_RST(IO_RST)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .reg_addr(reg_addr), .wr_data(wr_data),
        .ld_data(ld_data), .rd_done(rd_done), .conv_valid(conv_valid),
        .conv_data(conv_data), .conv_err(conv_err), .conv_chan(conv_chan),
        .rd_val(rd_val), .rdy_n(rdy_n), .mode_cfg(mode_cfg), .conf_cfg(conf_cfg),
        .io_cfg(io_cfg), .offset_cfg(offset_cfg), .gain_cfg(gain_cfg)
    );
endmodule

// File: tb/sdadc_spi_port_tb.sv
`timescale 1ns/1ps
module sdadc_spi_port_tb;
    localparam int DW = 24;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic spi_sclk = 1'b1, spi_cs_n = 1'b1, spi_mosi = 1'b0;
    logic spi_miso;
    logic conv_valid = 1'b0, conv_err = 1'b0;
    logic [DW-1:0] conv_data = '0;
    logic [2:0] conv_chan = '0;
    logic [15:0] mode_cfg, conf_cfg;
    logic [7:0] io_cfg;
    logic [DW-1:0] offset_cfg, gain_cfg;

    always #5 clk = ~clk;

    sdadc_spi_port #(.DW(DW)) u_dut (
        .clk(clk), .rst_n(rst_n), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso), .conv_valid(conv_valid),
        .conv_data(conv_data), .conv_err(conv_err), .conv_chan(conv_chan),
        .mode_cfg(mode_cfg), .conf_cfg(conf_cfg), .io_cfg(io_cfg),
        .offset_cfg(offset_cfg), .gain_cfg(gain_cfg)
    );

    typedef struct { logic [31:0] v; string tag; } item_t;
    item_t       exp_q[$];
    logic [31:0] got_q[$];
    event        got_ev;
    int n_cmp = 0, n_bad = 0;
    bit done = 1'b0;

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // scoreboard monitor
    initial begin
        forever begin
            @(got_ev);
            while (got_q.size() > 0) begin
                logic [31:0] g;
                item_t e;
                g = got_q.pop_front();
                if (exp_q.size() == 0) begin
                    n_cmp++; n_bad++;
                    $display("FAIL unexpected read: actual %h expected none", g);
                end else begin
                    e = exp_q.pop_front();
                    chk(g, e.v, e.tag);
                end
            end
        end
    end

    task automatic expect_val(input logic [31:0] v, input string tag);
        item_t e;
        e.v = v; e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic got(input logic [31:0] v);
        got_q.push_back(v);
        -> got_ev;
    endtask

    task automatic spi_bits(input logic [31:0] tx, input int n, output logic [31:0] rx);
        rx = '0;
        for (int i = n - 1; i >= 0; i--) begin
            spi_sclk = 1'b0;
            spi_mosi = tx[i];
            #80;
            rx = {rx[30:0], spi_miso};
            spi_sclk = 1'b1;
            #80;
        end
        spi_mosi = 1'b0;
    endtask

    task automatic cs_begin();
        spi_cs_n = 1'b0;
        #60;
    endtask

    task automatic cs_end();
        #60;
        spi_cs_n = 1'b1;
        #120;
    endtask

    task automatic rd_reg(input logic [7:0] cmd, input int len);
        logic [31:0] rx;
        cs_begin();
        spi_bits({24'h0, cmd}, 8, rx);
        spi_bits(32'h0, len, rx);
        cs_end();
        got(rx);
    endtask

    task automatic wr_reg(input logic [7:0] cmd, input logic [31:0] val, input int len);
        logic [31:0] rx;
        cs_begin();
        spi_bits({24'h0, cmd}, 8, rx);
        spi_bits(val, len, rx);
        cs_end();
    endtask

    task automatic conv(input logic [DW-1:0] d, input logic e, input logic [2:0] c);
        @(negedge clk);
        conv_valid = 1'b1; conv_data = d; conv_err = e; conv_chan = c;
        @(negedge clk);
        conv_valid = 1'b0;
        #3;
    endtask

    task automatic wait_miso_low(input string tag);
        for (int i = 0; i < 400; i++) begin
            if (spi_miso == 1'b0) break;
            @(negedge clk);
        end
        #3;
        chk({31'h0, spi_miso}, 32'h0, tag);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] rx, a, b;
        #103;
        rst_n = 1'b1;
        #100;
        // R12 reset values, R11 idle miso
        chk({16'h0, mode_cfg}, 32'h000A, "R12 mode reset");
        chk({16'h0, conf_cfg}, 32'h0710, "R12 conf reset");
        chk({24'h0, io_cfg}, 32'h00, "R12 io reset");
        chk({8'h0, offset_cfg}, 32'h800000, "R12 offset reset");
        chk({8'h0, gain_cfg}, 32'h500000, "R12 gain reset");
        chk({31'h0, spi_miso}, 32'h1, "R11 miso high with cs high");
        expect_val(32'h80, "R12/R5 status after reset"); rd_reg(8'h40, 8);
        expect_val(32'h4B, "R6 id");                     rd_reg(8'h60, 8);
        expect_val(32'h000000, "R12 data reset");        rd_reg(8'h58, DW);

        // R3 and R2 writes with read-back
        wr_reg(8'h08, 32'h2345, 16);
        chk({16'h0, mode_cfg}, 32'h2345, "R3 mode port");
        expect_val(32'h2345, "R3 mode readback"); rd_reg(8'h48, 16);
        wr_reg(8'h10, 32'hA5C3, 16);
        chk({16'h0, conf_cfg}, 32'hA5C3, "R3 conf port");
        expect_val(32'hA5C3, "R2 conf readback"); rd_reg(8'h50, 16);
        wr_reg(8'h28, 32'h3C, 8);
        chk({24'h0, io_cfg}, 32'h3C, "R3 io port");
        expect_val(32'h3C, "R2 io readback"); rd_reg(8'h68, 8);
        wr_reg(8'h30, 32'h123456, DW);
        chk({8'h0, offset_cfg}, 32'h123456, "R3 offset port");
        expect_val(32'h123456, "R2 offset readback"); rd_reg(8'h70, DW);
        wr_reg(8'h38, 32'hFEDCBA, DW);
        chk({8'h0, gain_cfg}, 32'hFEDCBA, "R3 gain port");
        expect_val(32'hFEDCBA, "R2 gain readback"); rd_reg(8'h78, DW);

        // R4 writes to read-only addresses are ignored
        wr_reg(8'h20, 32'h00, 8);
        expect_val(32'h4B, "R4 id unchanged after write"); rd_reg(8'h60, 8);
        wr_reg(8'h18, 32'hABCDEF, DW);
        expect_val(32'h000000, "R4 data unchanged after write"); rd_reg(8'h58, DW);
        cs_begin();
        spi_bits(32'h00, 8, rx);
        spi_bits(32'h60, 8, rx);
        spi_bits(32'h0, 8, rx);
        cs_end();
        expect_val(32'h4B, "R4 address-0 write has no data phase"); got(rx);

        // R1 guard bit
        cs_begin();
        spi_bits(32'hC8, 8, rx);
        spi_bits(32'h60, 8, rx);
        spi_bits(32'h0, 8, rx);
        cs_end();
        expect_val(32'h4B, "R1 guarded read-like byte dropped"); got(rx);
        cs_begin();
        spi_bits(32'h88, 8, rx);
        spi_bits(32'h48, 8, rx);
        spi_bits(32'h0, 16, rx);
        cs_end();
        expect_val(32'h2345, "R1 guarded write-like byte dropped"); got(rx);
        chk({16'h0, mode_cfg}, 32'h2345, "R1 mode port untouched");

        // R7 result latch and ready on miso
        conv(24'h5A5A5A, 1'b1, 3'd5);
        cs_begin();
        chk({31'h0, spi_miso}, 32'h0, "R7 miso shows ready");
        cs_end();
        expect_val(32'h45, "R5 status with result");  rd_reg(8'h40, 8);
        expect_val(32'h5A5A5A, "R7 data value");      rd_reg(8'h58, DW);
        expect_val(32'hC5, "R8 not-ready after read"); rd_reg(8'h40, 8);

        // R8 aborted read keeps ready
        conv(24'h0F0F0F, 1'b0, 3'd2);
        cs_begin();
        spi_bits(32'h58, 8, rx);
        spi_bits(32'h0, 10, rx);
        cs_end();
        expect_val(32'h02, "R8 abort keeps ready"); rd_reg(8'h40, 8);
        expect_val(32'h0F0F0F, "R8 full read");     rd_reg(8'h58, DW);
        expect_val(32'h82, "R8 set after full read"); rd_reg(8'h40, 8);

        // R8 result arriving during a read
        conv(24'h111111, 1'b0, 3'd1);
        cs_begin();
        spi_bits(32'h58, 8, rx);
        spi_bits(32'h0, 12, a);
        conv(24'h222222, 1'b0, 3'd3);
        spi_bits(32'h0, 12, b);
        cs_end();
        expect_val(32'h111111, "R8 read keeps loaded value"); got({8'h0, a[11:0], b[11:0]});
        expect_val(32'h03, "R8 ready kept by newer result"); rd_reg(8'h40, 8);
        expect_val(32'h222222, "R8 newer result readable");  rd_reg(8'h58, DW);

        // R9 streaming
        cs_begin();
        spi_bits(32'h5C, 8, rx);
        #100;
        chk({31'h0, spi_miso}, 32'h1, "R9 stream waits while not-ready");
        conv(24'h345678, 1'b0, 3'd4);
        wait_miso_low("R9 stream word ready");
        spi_bits(32'h0, DW, rx);
        expect_val(32'h345678, "R9 stream word 1"); got(rx);
        #40;
        chk({31'h0, spi_miso}, 32'h1, "R9 not-ready after stream word");
        conv(24'h9ABCDE, 1'b1, 3'd6);
        wait_miso_low("R9 second word ready");
        spi_bits(32'h580000, DW, rx);
        expect_val(32'h9ABCDE, "R9 stream word 2"); got(rx);
        spi_bits(32'h60, 8, rx);
        spi_bits(32'h0, 8, rx);
        cs_end();
        expect_val(32'h4B, "R9 stop code returns to command wait"); got(rx);
        expect_val(32'hC6, "R9 status after stream"); rd_reg(8'h40, 8);

        // R10 resync by 32 ones
        cs_begin();
        spi_bits(32'h2, 3, rx);
        spi_bits(32'hFFFFFFFF, 32, rx);
        spi_bits(32'h48, 8, rx);
        spi_bits(32'h0, 16, rx);
        cs_end();
        expect_val(32'h2345, "R10 resync then mode read"); got(rx);
        chk({16'h0, conf_cfg}, 32'hA5C3, "R10 registers kept");

        // R11 chip-select abort
        cs_begin();
        spi_bits(32'h70, 8, rx);
        spi_bits(32'h0, 10, rx);
        cs_end();
        chk({31'h0, spi_miso}, 32'h1, "R11 miso high after abort");
        expect_val(32'h4B, "R11 read after data abort"); rd_reg(8'h60, 8);
        cs_begin();
        spi_bits(32'h2, 3, rx);
        cs_end();
        expect_val(32'h4B, "R11 read after command abort"); rd_reg(8'h60, 8);

        #200;
        if (exp_q.size() != 0) begin
            n_cmp++; n_bad++;
            $display("FAIL scoreboard: actual %0d pending expected 0", exp_q.size());
        end
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule